// File: doc/BRIEF.md
# Multiplexer-free program/data address path

This block is the addressing core of a very small processor. It holds two address registers: the one that drives memory (called the front register here) and the one that waits for its turn (the back register). No multiplexer chooses between them. When a swap is requested, the back register's value goes through a +0/+1 incrementer into the front register. In the same edge, the old front value goes into the back register. The memory address output is always the front register.

A controller swaps the two registers twice per instruction. In the fetch phase the front register holds the instruction address. After the first swap it holds the data pointer, which can be used as it is or overwritten from an instruction operand. The second swap brings the program address back to the front. Setting the increment on either swap gives a free program-counter advance or a free post-increment of the data pointer. A one-bit phase sequencer tracks which of the two values is currently at the front, and the block reports it.

Top module: `addr_swap_path`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, mem_addr_o is 0 and phase_o is 0. Phase encoding: 0 means fetch, 1 means data.
- R2: On a clock edge with swap_i high, mem_addr_o takes the previous back-register value plus 1 when inc_sel_i is 1, or plus 0 when inc_sel_i is 0.
- R3: On a clock edge with swap_i high, the back register takes the previous mem_addr_o value. The next swap makes this visible at mem_addr_o.
- R4: Every edge with swap_i high inverts phase_o. Edges without a swap leave phase_o unchanged.
- R5: On an edge with swap_i low, load_i high and phase_o equal to 1, mem_addr_o takes load_addr_i. The back register is not changed.
- R6: On an edge with swap_i low, load_i high and phase_o equal to 0, the load is ignored. mem_addr_o and the back register keep their values.
- R7: When swap_i and load_i are both high, the swap is performed and load_addr_i has no effect.
- R8: On an edge with swap_i and load_i both low, mem_addr_o and the back register hold their values.
- R9: The increment wraps modulo 2^ADDR_W. An all-ones back value swapped with +1 gives address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swap_i | input | 1 | Exchange the front and back registers on this edge |
| inc_sel_i | input | 1 | Add 1 (1) or 0 (0) to the value moving into the front register |
| load_i | input | 1 | Write load_addr_i into the front register; honoured only in the data phase |
| load_addr_i | input | ADDR_W | Data address taken from the instruction operand |
| mem_addr_o | output | ADDR_W | Memory address, driven directly by the front register |
| phase_o | output | 1 | 0 = fetch address at the front, 1 = data address at the front |

## Verification
The bench runs a sequence of complete instructions. It uses swaps with +0 and with +1, operand loads between swaps, and bare data-pointer post-increments. These show whether the incrementer acts on the value entering the front register or on the value leaving it. Loads issued in the fetch phase, and swaps issued together with a load, separate correct gating and priority from a design that lets the operand overwrite the program address. A back register driven to all ones checks the wrap at the top of the address range.

// File: rtl/swap_addr_pkg.sv
package swap_addr_pkg;
  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;
endpackage

// File: rtl/swap_incr.sv
module swap_incr #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         inc_i,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb y_o = inc_i ? a_i + ONE : a_i;
endmodule

// File: rtl/swap_phase_seq.sv
module swap_phase_seq
  import swap_addr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   swap_i,
  output phase_e phase_o,
  output logic   load_ok_o
);
  phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= PH_FETCH;
    else if (swap_i) phase_q <= (phase_q == PH_FETCH) ? PH_DATA : PH_FETCH;
  end

  assign phase_o   = phase_q;
  // operand load may only overwrite the data pointer, never the fetch address
  assign load_ok_o = (phase_q == PH_DATA);
endmodule

// File: rtl/swap_reg_pair.sv
module swap_reg_pair #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         swap_i,
  input  logic         load_i,
  input  logic [W-1:0] load_addr_i,
  input  logic [W-1:0] sum_i,
  output logic [W-1:0] back_o,
  output logic [W-1:0] front_o
);
  logic [W-1:0] back_q, front_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      back_q  <= '0;
      front_q <= '0;
    end else if (swap_i) begin
      front_q <= sum_i;
      back_q  <= front_q;
    end else if (load_i) begin
      front_q <= load_addr_i;
    end
  end

  assign back_o  = back_q;
  assign front_o = front_q;
endmodule

// File: rtl/addr_swap_path.sv
module addr_swap_path
  import swap_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swap_i,
  input  logic              inc_sel_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              phase_o
);
  phase_e            phase;
  logic              load_ok;
  logic [ADDR_W-1:0] back_q, front_q, sum;

  swap_phase_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .swap_i    (swap_i),
    .phase_o   (phase),
    .load_ok_o (load_ok)
  );

  // the only arithmetic: back register through +0/+1 on its way to the front
  swap_incr #(.W(ADDR_W)) u_inc (
    .a_i   (back_q),
    .inc_i (inc_sel_i),
    .y_o   (sum)
  );

  swap_reg_pair #(.W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .swap_i      (swap_i),
    .load_i      (load_i & load_ok),
    .load_addr_i (load_addr_i),
    .sum_i       (sum),
    .back_o      (back_q),
    .front_o     (front_q)
  );

  assign mem_addr_o = front_q;
  assign phase_o    = phase;
endmodule

// File: rtl/addr_swap_path_chk.sv
module addr_swap_path_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              swap_i,
  input logic              inc_sel_i,
  input logic              load_i,
  input logic [ADDR_W-1:0] load_addr_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              phase_o,
  input logic [ADDR_W-1:0] back_q
);
  AST_SWAP_FRONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> mem_addr_o == ADDR_W'($past(back_q) + ADDR_W'($past(inc_sel_i)))); // R2
  AST_SWAP_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> back_q == $past(mem_addr_o)); // R3
  AST_PHASE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i |=> phase_o != $past(phase_o)); // R4
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_i |=> $stable(phase_o)); // R4
  AST_LOAD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swap_i && load_i && phase_o) |=> mem_addr_o == $past(load_addr_i) && $stable(back_q)); // R5
  AST_LOAD_FETCH_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swap_i && load_i && !phase_o) |=> $stable(mem_addr_o) && $stable(back_q)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!swap_i && !load_i) |=> $stable(mem_addr_o) && $stable(back_q)); // R8
endmodule

bind addr_swap_path addr_swap_path_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .swap_i      (swap_i),
  .inc_sel_i   (inc_sel_i),
  .load_i      (load_i),
  .load_addr_i (load_addr_i),
  .mem_addr_o  (mem_addr_o),
  .phase_o     (phase_o),
  .back_q      (back_q)
);

// File: tb/tb_addr_swap_path.sv
module tb_addr_swap_path;
  localparam int  CLK_PERIOD = 10;
  localparam int  AW = 8;

  typedef struct {
    logic [AW-1:0] addr;
    logic          ph;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          swap_i = 1'b0, inc_sel_i = 1'b0, load_i = 1'b0;
  logic [AW-1:0] load_addr_i = '0;
  logic [AW-1:0] mem_addr_o;
  logic          phase_o;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  // bench reference model
  logic [AW-1:0] m_front = '0, m_back = '0;
  logic          m_ph = 1'b0;

  addr_swap_path #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .swap_i(swap_i), .inc_sel_i(inc_sel_i),
    .load_i(load_i), .load_addr_i(load_addr_i), .mem_addr_o(mem_addr_o), .phase_o(phase_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [AW-1:0] a, input logic p, input exp_t e);
    n_chk++;
    if (a !== e.addr || p !== e.ph) begin
      n_fail++;
      $display("FAIL %s: addr=%0h phase=%0b expected addr=%0h phase=%0b", e.tag, a, p, e.addr, e.ph);
    end
  endtask

  task automatic step(input logic sw, input logic inc, input logic ld,
                      input logic [AW-1:0] la, input string tag);
    exp_t e;
    @(negedge clk);
    swap_i = sw; inc_sel_i = inc; load_i = ld; load_addr_i = la;
    if (sw) begin
      logic [AW-1:0] f;
      f       = m_back + (inc ? AW'(1) : AW'(0));
      m_back  = m_front;
      m_front = f;
      m_ph    = ~m_ph;
    end else if (ld && m_ph) begin
      m_front = la;
    end
    e.addr = m_front; e.ph = m_ph; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare one expected item per edge, just after it
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(mem_addr_o, phase_o, e);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    exp_t r;
    #(CLK_PERIOD * 3);
    r.addr = '0; r.ph = 1'b0; r.tag = "R1 in reset";
    check(mem_addr_o, phase_o, r);
    @(negedge clk); rst_ni = 1'b1;
    step(0, 0, 0, 8'h00, "R1 first cycle after reset");
    step(1, 0, 0, 8'h00, "R2 swap +0 into data phase");
    step(0, 0, 1, 8'h40, "R5 load in data phase");
    step(1, 1, 0, 8'h00, "R2 swap +1 back to fetch");
    step(0, 0, 1, 8'h77, "R6 load in fetch phase ignored");
    step(1, 1, 0, 8'h00, "R3 back held old data pointer, +1 post-increment");
    step(0, 0, 0, 8'h00, "R8 idle hold");
    step(0, 0, 0, 8'h00, "R8 idle hold again");
    step(1, 1, 0, 8'h00, "R3 fetch address returns advanced");
    step(1, 0, 1, 8'h99, "R7 swap wins over load");
    step(0, 1, 1, 8'hFF, "R5 load all ones data pointer");
    step(1, 1, 0, 8'h00, "R4 swap to fetch");
    step(1, 1, 0, 8'h00, "R9 all ones plus one wraps");
    step(0, 0, 1, 8'h12, "R5 load after wrap");
    step(1, 0, 0, 8'h00, "R3 swap +0 restores fetch");
    step(1, 0, 0, 8'h00, "R4 second +0 swap");
    step(0, 1, 0, 8'h00, "R8 inc without swap has no effect");
    @(negedge clk); swap_i = 0; load_i = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end
endmodule